// File: doc/BRIEF.md
# Multiphase PWM Generator

This block drives up to six gate-control outputs of a switching power stage. A period counter advances on a prescaled clock enable. Each output compares the counter with its own start edge and a shared width to form its pulse. In pulse-width mode the width is the duty command. In phase-shift mode every output runs at half the period, and a selectable group of outputs is delayed by the duty command. The duty command carries a 9-bit integer part and a 6-bit fraction. When dither is on, a fraction accumulator adds one count to selected cycles, so the average over many cycles is finer than one count.

Cycle timing comes from the counter wrapping at the period value. An external sync input can also restart the cycle, but only after it has been seen low for long enough. Every cycle-level setting is shadowed and taken up only at a cycle boundary. The enable input has a programmable active level. An over-current flag latches a fault. Each output has its own stop level for the disabled state and for the fault state. A software bypass can force chosen outputs to a fixed level. A terminate request from a current limiter cuts every modulated pulse for the rest of the cycle.

Top module: `mpwm_gen`

## Requirements
- R1: The counter advances on a clock enable chosen by `speed_sel`: 00 gives every clock, 01 gives every 4th clock, and 10 or 11 give every 8th clock. The prescaler restarts each time the block enters the running state.
- R2: While running, the counter steps from 0 up to the shadowed period and then returns to 0. One cycle therefore lasts period+1 counting steps.
- R3: In pulse-width mode (`mode_psm`=0), output i is high while (count − edge_i) mod (period+1) < duty. Edge_i is bits [i*10+9:i*10] of `rise_pos`. The output is registered and shows the counter value of the previous clock.
- R4: In phase-shift mode (`mode_psm`=1), every output is high for floor((period+1)/2) counts. Its start is edge_i, plus the duty for outputs whose `lag_sel` bit is 1. The start is taken modulo period+1.
- R5: Period, duty, edges, mode and lag group are captured on the counting step that ends a cycle, and on every clock while not running. A change at any other time has no effect on the cycle in progress.
- R6: `duty_cmd[14:6]` is the integer duty and `duty_cmd[5:0]` is the fraction. With `dither_en`=1, the fraction is added into a 6-bit accumulator at each cycle start. A carry out adds one count to that cycle's duty. The accumulator is cleared while dither is off or the block is not running.
- R7: With `sync_en`=1, `sync_in` is registered once and sampled on counting steps. A sample of 1 that follows at least 3 consecutive samples of 0 restarts the cycle at that step. Shorter low periods, and all samples when `sync_en`=0, have no effect.
- R8: The block runs when `en_in` equals `en_pol`. Otherwise it is disabled.
- R9: While disabled with no fault, each output i drives `stop_dis[i]`, and the counter is held at 0.
- R10: A high `ocp_flag` latches a fault state in which output i drives `stop_ocp[i]`. The fault clears only when `ocp_flag` is low and the enable is inactive. The block then goes to the disabled state.
- R11: While running, an output with its `byp_en` bit set drives its `byp_val` bit. The other outputs keep modulating.
- R12: While running, `term_req` forces all modulated outputs low from the next clock. This holds until the cycle ends, even after the request drops. Bypassed outputs are not affected.
- R13: During reset all outputs are low. After reset the block starts in the disabled state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_in | input | 1 | Supply on/off request |
| en_pol | input | 1 | Active level of en_in |
| speed_sel | input | 2 | Counting clock prescale select |
| mode_psm | input | 1 | 0 pulse-width, 1 phase-shift |
| period | input | 10 | Last counter value of a cycle |
| duty_cmd | input | 15 | Duty: integer [14:6], fraction [5:0] |
| dither_en | input | 1 | Enable fractional duty accumulation |
| rise_pos | input | 60 | Per-output start edge, 10 bits each |
| lag_sel | input | 6 | Outputs delayed by duty in phase-shift mode |
| sync_en | input | 1 | Accept external cycle restarts |
| sync_in | input | 1 | External frame sync |
| term_req | input | 1 | Terminate pulses for rest of cycle |
| ocp_flag | input | 1 | Over-current shutdown request |
| stop_dis | input | 6 | Output levels while disabled |
| stop_ocp | input | 6 | Output levels while in fault |
| byp_en | input | 6 | Per-output software bypass enable |
| byp_val | input | 6 | Per-output bypass level |
| gate | output | 6 | Gate-control outputs |

## Verification
A cycle-accurate model runs alongside the design and predicts every output bit on every clock. It is driven through the following stimulus sets:
- Pulse-width mode with staggered edges, which separates edge placement from width.
- Phase-shift mode with a mixed lag group, which shows whether the delay is applied only to lagging outputs and wraps at the cycle end.
- Duty and period changes made mid-cycle, which show whether the shadow registers capture only at boundaries.
- Slow prescaler codes, which stretch every step and expose tick-gating errors.
- Sync trains with long and with too-short low times, which separate accepted restarts from ignored ones.

Windowed high-time counts cross-check the model against plain arithmetic: duty per period, the dither carry pattern (13 high clocks in 40 at duty 3.25), and sync-locked frames.

// File: rtl/mpwm_pkg.sv
package mpwm_pkg;
  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_RUN   = 2'd1,
    ST_FAULT = 2'd2
  } mpwm_state_e;
endpackage

// File: rtl/mpwm_tick_gen.sv
module mpwm_tick_gen #(
  parameter int DIV_MID  = 4,
  parameter int DIV_SLOW = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] speed_sel,
  output logic       tick
);
  localparam int PSC_W = $clog2(DIV_SLOW);
  localparam logic [PSC_W-1:0] LIM_FULL = '0;
  localparam logic [PSC_W-1:0] LIM_MID  = PSC_W'(DIV_MID - 1);
  localparam logic [PSC_W-1:0] LIM_SLOW = PSC_W'(DIV_SLOW - 1);

  logic [PSC_W-1:0] psc_q, psc_d, lim;

  always_comb begin
    case (speed_sel)
      2'b00:   lim = LIM_FULL;
      2'b01:   lim = LIM_MID;
      default: lim = LIM_SLOW;
    endcase
    tick = run && (psc_q == lim);
    if (!run || psc_q >= lim) psc_d = '0;
    else                      psc_d = psc_q + PSC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) psc_q <= '0;
    else        psc_q <= psc_d;
  end
endmodule

// File: rtl/mpwm_sync_qual.sv
module mpwm_sync_qual #(
  parameter int MIN_LOW = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  input  logic sync_en,
  input  logic sync_in,
  output logic sync_acc
);
  localparam int LOW_W = $clog2(MIN_LOW + 1);
  localparam logic [LOW_W-1:0] LOW_SAT = LOW_W'(MIN_LOW);

  logic             sync_q;
  logic [LOW_W-1:0] lowc_q, lowc_d;

  always_comb begin
    sync_acc = run && tick && sync_en && sync_q && (lowc_q >= LOW_SAT);
    if (!run)          lowc_d = '0;
    else if (!tick)    lowc_d = lowc_q;
    else if (sync_q)   lowc_d = '0;
    else if (lowc_q == LOW_SAT) lowc_d = lowc_q;
    else               lowc_d = lowc_q + LOW_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 1'b0;
      lowc_q <= '0;
    end else begin
      sync_q <= sync_in;
      lowc_q <= lowc_d;
    end
  end
endmodule

// File: rtl/mpwm_timebase.sv
module mpwm_timebase #(
  parameter int NCH    = 6,
  parameter int CNT_W  = 10,
  parameter int DUTY_W = 9,
  parameter int FRAC_W = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     run,
  input  logic                     tick,
  input  logic                     sync_acc,
  input  logic [CNT_W-1:0]         period,
  input  logic [DUTY_W+FRAC_W-1:0] duty_cmd,
  input  logic                     dither_en,
  input  logic                     mode_psm,
  input  logic [NCH*CNT_W-1:0]     rise_pos,
  input  logic [NCH-1:0]           lag_sel,
  output logic [CNT_W-1:0]         cnt_q,
  output logic [CNT_W-1:0]         per_sh,
  output logic [CNT_W-1:0]         duty_sh,
  output logic                     psm_sh,
  output logic [NCH*CNT_W-1:0]     rise_sh,
  output logic [NCH-1:0]           lag_sh,
  output logic                     frame_start
);
  localparam int PAD_W = CNT_W - DUTY_W;

  logic [CNT_W-1:0]  cnt_d, duty_d;
  logic [FRAC_W-1:0] acc_q, acc_d;
  logic [FRAC_W:0]   acc_sum;
  logic              load, dith_run;
  logic [DUTY_W-1:0] duty_int;
  logic [FRAC_W-1:0] duty_frac;

  always_comb begin
    duty_int    = duty_cmd[DUTY_W+FRAC_W-1:FRAC_W];
    duty_frac   = duty_cmd[FRAC_W-1:0];
    frame_start = run && tick && ((cnt_q == per_sh) || sync_acc);
    load        = !run || frame_start;
    dith_run    = run && dither_en;
    acc_sum     = {1'b0, acc_q} + {1'b0, duty_frac};

    if (!run || frame_start) cnt_d = '0;
    else if (tick)           cnt_d = cnt_q + CNT_W'(1);
    else                     cnt_d = cnt_q;

    duty_d = {{PAD_W{1'b0}}, duty_int} +
             {{(CNT_W-1){1'b0}}, dith_run & acc_sum[FRAC_W]};

    if (load) acc_d = dith_run ? acc_sum[FRAC_W-1:0] : '0;
    else      acc_d = acc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      acc_q <= acc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_sh  <= '0;
      duty_sh <= '0;
      psm_sh  <= 1'b0;
      rise_sh <= '0;
      lag_sh  <= '0;
    end else if (load) begin
      per_sh  <= period;
      duty_sh <= duty_d;
      psm_sh  <= mode_psm;
      rise_sh <= rise_pos;
      lag_sh  <= lag_sel;
    end
  end
endmodule

// File: rtl/mpwm_lane.sv
module mpwm_lane #(
  parameter int CNT_W = 10
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  mpwm_pkg::mpwm_state_e     st,
  input  logic [CNT_W-1:0]          cnt,
  input  logic [CNT_W-1:0]          per,
  input  logic [CNT_W-1:0]          duty,
  input  logic                      psm,
  input  logic [CNT_W-1:0]          rise,
  input  logic                      lag,
  input  logic                      kill,
  input  logic                      stop_dis,
  input  logic                      stop_ocp,
  input  logic                      byp_en,
  input  logic                      byp_val,
  output logic                      gate_q
);
  import mpwm_pkg::*;
  localparam int W1 = CNT_W + 1;

  logic [W1-1:0] p1, shift, sraw, start, pos, width, cnt_x;
  logic          on, gate_d;

  always_comb begin
    cnt_x = {1'b0, cnt};
    p1    = {1'b0, per} + W1'(1);
    shift = (psm && lag) ? {1'b0, duty} : '0;
    sraw  = {1'b0, rise} + shift;
    start = (sraw >= p1) ? (sraw - p1) : sraw;
    pos   = (cnt_x >= start) ? (cnt_x - start) : (cnt_x + p1 - start);
    width = psm ? (p1 >> 1) : {1'b0, duty};
    on    = (pos < width);

    case (st)
      ST_FAULT: gate_d = stop_ocp;
      ST_RUN:   gate_d = byp_en ? byp_val : (on && !kill);
      default:  gate_d = stop_dis;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= gate_d;
  end
endmodule

// File: rtl/mpwm_gen.sv
module mpwm_gen #(
  parameter int NCH     = 6,
  parameter int CNT_W   = 10,
  parameter int DUTY_W  = 9,
  parameter int FRAC_W  = 6,
  parameter int MIN_LOW = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en_in,
  input  logic                     en_pol,
  input  logic [1:0]               speed_sel,
  input  logic                     mode_psm,
  input  logic [CNT_W-1:0]         period,
  input  logic [DUTY_W+FRAC_W-1:0] duty_cmd,
  input  logic                     dither_en,
  input  logic [NCH*CNT_W-1:0]     rise_pos,
  input  logic [NCH-1:0]           lag_sel,
  input  logic                     sync_en,
  input  logic                     sync_in,
  input  logic                     term_req,
  input  logic                     ocp_flag,
  input  logic [NCH-1:0]           stop_dis,
  input  logic [NCH-1:0]           stop_ocp,
  input  logic [NCH-1:0]           byp_en,
  input  logic [NCH-1:0]           byp_val,
  output logic [NCH-1:0]           gate
);
  import mpwm_pkg::*;

  mpwm_state_e          state_q, state_d;
  logic                 en_act, run_st, tick, sync_acc, frame_start;
  logic                 hold_q, hold_d, kill;
  logic [CNT_W-1:0]     cnt_q, per_sh, duty_sh;
  logic                 psm_sh;
  logic [NCH*CNT_W-1:0] rise_sh;
  logic [NCH-1:0]       lag_sh;

  always_comb begin
    en_act = (en_in == en_pol);
    run_st = (state_q == ST_RUN);
    if (ocp_flag) state_d = ST_FAULT;
    else begin
      case (state_q)
        ST_OFF:   state_d = en_act ? ST_RUN : ST_OFF;
        ST_RUN:   state_d = en_act ? ST_RUN : ST_OFF;
        ST_FAULT: state_d = en_act ? ST_FAULT : ST_OFF;
        default:  state_d = ST_OFF;
      endcase
    end
    kill   = hold_q || term_req;
    hold_d = run_st && !frame_start && kill;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      hold_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      hold_q  <= hold_d;
    end
  end

  mpwm_tick_gen u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run_st),
    .speed_sel (speed_sel),
    .tick      (tick)
  );

  mpwm_sync_qual #(.MIN_LOW(MIN_LOW)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_st),
    .tick     (tick),
    .sync_en  (sync_en),
    .sync_in  (sync_in),
    .sync_acc (sync_acc)
  );

  mpwm_timebase #(
    .NCH(NCH), .CNT_W(CNT_W), .DUTY_W(DUTY_W), .FRAC_W(FRAC_W)
  ) u_tb (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (run_st),
    .tick        (tick),
    .sync_acc    (sync_acc),
    .period      (period),
    .duty_cmd    (duty_cmd),
    .dither_en   (dither_en),
    .mode_psm    (mode_psm),
    .rise_pos    (rise_pos),
    .lag_sel     (lag_sel),
    .cnt_q       (cnt_q),
    .per_sh      (per_sh),
    .duty_sh     (duty_sh),
    .psm_sh      (psm_sh),
    .rise_sh     (rise_sh),
    .lag_sh      (lag_sh),
    .frame_start (frame_start)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_lane
    mpwm_lane #(.CNT_W(CNT_W)) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .st       (state_q),
      .cnt      (cnt_q),
      .per      (per_sh),
      .duty     (duty_sh),
      .psm      (psm_sh),
      .rise     (rise_sh[i*CNT_W +: CNT_W]),
      .lag      (lag_sh[i]),
      .kill     (kill),
      .stop_dis (stop_dis[i]),
      .stop_ocp (stop_ocp[i]),
      .byp_en   (byp_en[i]),
      .byp_val  (byp_val[i]),
      .gate_q   (gate[i])
    );
  end
endmodule

// File: rtl/mpwm_gen_chk.sv
module mpwm_gen_chk #(
  parameter int NCH   = 6,
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_in,
  input logic             en_pol,
  input logic             ocp_flag,
  input logic             term_req,
  input logic [NCH-1:0]   stop_dis,
  input logic [NCH-1:0]   stop_ocp,
  input logic [NCH-1:0]   byp_en,
  input logic [NCH-1:0]   byp_val,
  input logic [NCH-1:0]   gate,
  input logic             run_st,
  input logic             sync_acc,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] per_sh
);
  logic [1:0] cyc_q;
  logic       cyc_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cyc_q <= '0;
    else if (cyc_q != 2'd3)  cyc_q <= cyc_q + 2'd1;
  end
  assign cyc_ok = (cyc_q >= 2'd2);

  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= per_sh);

  assert_sync_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sync_acc |=> (cnt_q == '0));

  assert_dis_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_ok && $past(en_in != en_pol, 2) && !$past(ocp_flag, 2))
      |-> (gate == $past(stop_dis)));

  assert_ocp_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_ok && $past(ocp_flag, 2)) |-> (gate == $past(stop_ocp)));

  assert_bypass_R11: assert property (@(posedge clk) disable iff (!rst_n)
    run_st |=> (((gate ^ $past(byp_val)) & $past(byp_en)) == '0));

  assert_term_cut_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (run_st && term_req) |=> ((gate & ~$past(byp_en)) == '0));
endmodule

bind mpwm_gen mpwm_gen_chk #(.NCH(NCH), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en_in    (en_in),
  .en_pol   (en_pol),
  .ocp_flag (ocp_flag),
  .term_req (term_req),
  .stop_dis (stop_dis),
  .stop_ocp (stop_ocp),
  .byp_en   (byp_en),
  .byp_val  (byp_val),
  .gate     (gate),
  .run_st   (run_st),
  .sync_acc (sync_acc),
  .cnt_q    (cnt_q),
  .per_sh   (per_sh)
);

// File: tb/sim_mpwm_gen.sv
module sim_mpwm_gen;
  localparam int NCH = 6, CNT_W = 10, DUTY_W = 9, FRAC_W = 6;
  localparam int DW = DUTY_W + FRAC_W;

  logic clk, rst_n, en_in, en_pol, mode_psm, dither_en, sync_en, sync_in;
  logic term_req, ocp_flag;
  logic [1:0]           speed_sel;
  logic [CNT_W-1:0]     period;
  logic [DW-1:0]        duty_cmd;
  logic [NCH*CNT_W-1:0] rise_pos;
  logic [NCH-1:0]       lag_sel, stop_dis, stop_ocp, byp_en, byp_val, gate;

  mpwm_gen u0 (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int    checks = 0, errors = 0;
  bit    done = 1'b0;
  string cur_req = "R13";
  logic [NCH-1:0] exp_q[$];

  // reference model state
  int m_state, m_psc, m_lowc, m_cnt, m_per, m_duty, m_acc;
  bit m_syncq, m_psm, m_hold;
  int m_rise[NCH];
  logic [NCH-1:0] m_lag;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_psc = 0; m_lowc = 0; m_cnt = 0; m_per = 0; m_duty = 0;
      m_acc = 0; m_syncq = 0; m_psm = 0; m_hold = 0; m_lag = '0;
      for (int i = 0; i < NCH; i++) m_rise[i] = 0;
    end else begin
      bit run, tick, acc_ok, fs, kill, enact, load, carry;
      int lim, nst, p1, s, pos, w, sum;
      logic [NCH-1:0] g;
      enact = (en_in == en_pol);
      run   = (m_state == 1);
      lim   = (speed_sel == 2'b00) ? 0 : (speed_sel == 2'b01) ? 3 : 7;
      tick  = run && (m_psc == lim);
      acc_ok = run && tick && sync_en && m_syncq && (m_lowc >= 3);
      fs    = run && tick && ((m_cnt == m_per) || acc_ok);
      kill  = m_hold || term_req;
      p1    = m_per + 1;
      for (int i = 0; i < NCH; i++) begin
        s = m_rise[i] + ((m_psm && m_lag[i]) ? m_duty : 0);
        if (s >= p1) s = s - p1;
        pos = (m_cnt >= s) ? m_cnt - s : m_cnt + p1 - s;
        w = m_psm ? p1 / 2 : m_duty;
        if (m_state == 2)      g[i] = stop_ocp[i];
        else if (m_state == 0) g[i] = stop_dis[i];
        else if (byp_en[i])    g[i] = byp_val[i];
        else                   g[i] = (pos < w) && !kill;
      end
      if (ocp_flag) nst = 2;
      else if (!enact) nst = 0;
      else nst = (m_state == 0) ? 1 : m_state;
      load = !run || fs;
      sum = m_acc + int'(duty_cmd[FRAC_W-1:0]);
      carry = (sum >= 64);
      if (load) begin
        m_per  = int'(period);
        m_duty = int'(duty_cmd[DW-1:FRAC_W]) + ((run && dither_en && carry) ? 1 : 0);
        m_acc  = (run && dither_en) ? sum % 64 : 0;
        m_psm  = mode_psm;
        m_lag  = lag_sel;
        for (int i = 0; i < NCH; i++) m_rise[i] = int'(rise_pos[i*CNT_W +: CNT_W]);
      end
      if (!run) m_lowc = 0;
      else if (tick) m_lowc = m_syncq ? 0 : ((m_lowc == 3) ? 3 : m_lowc + 1);
      m_syncq = sync_in;
      m_psc = (!run || m_psc >= lim) ? 0 : m_psc + 1;
      m_cnt = (!run || fs) ? 0 : (tick ? m_cnt + 1 : m_cnt);
      m_hold = run && !fs && kill;
      m_state = nst;
      exp_q.push_back(g);
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && exp_q.size() > 0) begin
      logic [NCH-1:0] e;
      e = exp_q.pop_front();
      checks++;
      if (gate !== e) begin
        errors++;
        $display("FAIL %s gate actual %b expected %b at %0t", cur_req, gate, e, $time);
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clocks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic highs(input int ch, input int n, output int cnt);
    cnt = 0;
    repeat (n) begin
      @(negedge clk);
      cnt += int'(gate[ch]);
    end
  endtask

  task automatic set_duty(input int di, input int fr);
    duty_cmd = {DUTY_W'(di), FRAC_W'(fr)};
  endtask

  initial begin
    int h;
    rst_n = 1'b0; en_in = 1'b0; en_pol = 1'b1; mode_psm = 1'b0; dither_en = 1'b0;
    sync_en = 1'b0; sync_in = 1'b0; term_req = 1'b0; ocp_flag = 1'b0;
    speed_sel = 2'b00; period = 10'd9; set_duty(3, 0);
    lag_sel = 6'b000000; stop_dis = 6'b101010; stop_ocp = 6'b010011;
    byp_en = '0; byp_val = '0;
    for (int i = 0; i < NCH; i++) rise_pos[i*CNT_W +: CNT_W] = CNT_W'(i);
    clocks(3);
    chk("R13 reset outputs low", int'(gate), 0);
    rst_n = 1'b1;
    clocks(3);
    chk("R13 disabled after reset", int'(gate), int'(stop_dis));

    cur_req = "R3"; en_in = 1'b1;
    clocks(25);
    highs(0, 20, h); chk("R3 pwm duty 3 of 10", h, 6);
    highs(3, 20, h); chk("R3 pwm edge 3", h, 6);
    set_duty(12, 0); clocks(12);
    highs(1, 20, h); chk("R3 duty above period stays high", h, 20);

    cur_req = "R5"; set_duty(3, 0);
    clocks(4); set_duty(6, 0); clocks(3); period = 10'd14;
    clocks(40);
    highs(0, 30, h); chk("R5 new duty and period", h, 12);

    cur_req = "R2"; period = 10'd4; set_duty(1, 0);
    clocks(20);
    highs(0, 25, h); chk("R2 period 4 cycle of 5", h, 5);

    cur_req = "R1"; period = 10'd4; set_duty(2, 0); speed_sel = 2'b01;
    clocks(45);
    highs(0, 40, h); chk("R1 divide by 4", h, 16);
    speed_sel = 2'b11; clocks(90);
    highs(0, 80, h); chk("R1 divide by 8", h, 32);
    speed_sel = 2'b00;

    cur_req = "R4"; period = 10'd9; set_duty(2, 0); mode_psm = 1'b1; lag_sel = 6'b110010;
    clocks(30);
    highs(0, 20, h); chk("R4 half period width", h, 10);
    highs(4, 20, h); chk("R4 lagging output width", h, 10);
    set_duty(7, 0); clocks(30);
    mode_psm = 1'b0; lag_sel = '0;

    cur_req = "R6"; set_duty(3, 16); dither_en = 1'b1;
    clocks(50);
    highs(0, 40, h); chk("R6 dither 3.25", h, 13);
    highs(0, 40, h); chk("R6 dither repeat", h, 13);
    dither_en = 1'b0; set_duty(3, 0);

    cur_req = "R7"; period = 10'd200; sync_en = 1'b1;
    repeat (6) begin
      sync_in = 1'b0; clocks(15); sync_in = 1'b1; clocks(5);
    end
    h = 0;
    repeat (2) begin
      int hh;
      sync_in = 1'b0; fork highs(0, 15, hh); join h += hh;
      sync_in = 1'b1; fork highs(0, 5, hh); join h += hh;
    end
    chk("R7 locked to sync", h, 6);
    sync_in = 1'b1; clocks(10);
    for (int k = 0; k < 6; k++) begin
      sync_in = 1'b0; clocks(2); sync_in = 1'b1; clocks(30);
    end
    sync_in = 1'b0; clocks(1); sync_in = 1'b1;
    clocks(210);
    highs(0, 201, h); chk("R7 short lows ignored", h, 3);
    sync_en = 1'b0; sync_in = 1'b0;
    for (int k = 0; k < 3; k++) begin
      clocks(10); sync_in = 1'b1; clocks(10); sync_in = 1'b0;
    end
    period = 10'd9; clocks(220);

    cur_req = "R12"; set_duty(8, 0);
    clocks(3); term_req = 1'b1; @(negedge clk); term_req = 1'b0;
    clocks(25);
    term_req = 1'b1; clocks(5);
    highs(0, 20, h); chk("R12 held terminate", h, 0);
    term_req = 1'b0; clocks(15);
    set_duty(3, 0);

    cur_req = "R11"; byp_en = 6'b000100; byp_val = 6'b000100;
    clocks(3);
    highs(2, 20, h); chk("R11 bypass high", h, 20);
    highs(0, 20, h); chk("R11 others modulate", h, 6);
    byp_val = 6'b000000; clocks(3);
    highs(2, 20, h); chk("R11 bypass low", h, 0);
    byp_en = '0;

    cur_req = "R9"; en_in = 1'b0; clocks(3);
    chk("R9 disable stop levels", int'(gate), int'(stop_dis));
    stop_dis = 6'b011001; clocks(2);
    chk("R9 new stop levels", int'(gate), int'(stop_dis));
    en_in = 1'b1; clocks(20);

    cur_req = "R8"; en_pol = 1'b0; clocks(3);
    chk("R8 active low, input high disables", int'(gate), int'(stop_dis));
    en_in = 1'b0; clocks(15);
    highs(0, 20, h); chk("R8 active low runs", h, 6);

    cur_req = "R10"; ocp_flag = 1'b1; @(negedge clk); ocp_flag = 1'b0;
    clocks(3);
    chk("R10 fault stop levels", int'(gate), int'(stop_ocp));
    clocks(10);
    chk("R10 fault latched while enabled", int'(gate), int'(stop_ocp));
    en_in = 1'b1; clocks(3);
    chk("R10 fault cleared to disabled", int'(gate), int'(stop_dis));
    en_in = 1'b0; clocks(20);
    highs(0, 20, h); chk("R10 restart after clear", h, 6);

    clocks(3);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL %s watchdog actual timeout expected completion", cur_req);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule